// File: doc/BRIEF.md
# Slotted Backoff and Deferral Engine

This block runs the medium-access countdown for a wireless MAC transmitter. Firmware programs the slot length and three interframe wait lengths in microseconds, picks a wait class with a 16-bit control word, and starts a procedure by writing a slot count. The engine first waits out the selected interframe space. It then decrements the slot count once per idle slot. When the count reaches zero it fires a single-cycle transmit-now pulse and returns to idle.

Time is measured in pulses of an external one-microsecond tick. The medium counts as busy when either the physical carrier-sense input or the virtual (NAV) busy input is high. Busy during the wait or the countdown freezes the engine. It resumes counting only after the medium has been idle for two full slots. A status word reports the state and the remaining count. A free-running 16-bit pseudo-random word is offered for firmware to draw backoff values from.

Top module: `backoff_engine`

## Requirements
- R1: After reset, status reads 0, tx_now is low, and the random word holds the seed 0xACE1 until the first clock after reset is released.
- R2: A write with cfg_addr 0, 1, 2 or 3 sets the slot, SIFS, PIFS or DIFS length in microseconds (reset values 9, 10, 19, 28). Address 4 sets the control word (reset 0x4c1d). Address 5 loads cfg_wdata[11:0] as the slot count and enters the IFS wait on the next clock.
- R3: The control word selects the wait length: 0x4021 gives SIFS, 0x4d95 gives PIFS, 0x4c1d gives DIFS, 0x4001 gives zero, and any other value gives DIFS. The wait ends on the clock after as many ticks as the wait length have been counted while idle, and the engine then enters counting.
- R4: While counting and idle with a nonzero count, the count drops by one each time a slot's worth of ticks has elapsed. Only a load can raise it.
- R5: If physical or virtual busy is high during the wait or counting, the engine enters the frozen state on the next clock, and the count holds.
- R6: From the frozen state the engine returns to counting only after twice the slot length of ticks with both busy inputs low. Any busy cycle restarts this guard.
- R7: When counting, idle and at count zero, tx_now is high for exactly one cycle and the state returns to idle.
- R8: Status bits [1:0] hold the state (00 idle, 01 IFS wait, 10 counting, 11 frozen). Bits [3:2] are zero and bits [15:4] hold the remaining slot count.
- R9: The random word advances every clock: it shifts left by one, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. It is never zero.
- R10: A count load during any state, including counting, discards the current procedure and restarts from the IFS wait with the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| phy_busy | input | 1 | Physical carrier sensed busy |
| nav_busy | input | 1 | Virtual carrier (NAV) busy |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| tx_now | output | 1 | One-cycle transmit-now pulse |
| status | output | 16 | State and remaining count |
| rand_val | output | 16 | Pseudo-random word |

## Verification
The embedded assertions check these on every cycle:
- the freeze on busy and the hold while busy persists;
- that the count never rises without a load;
- the single-cycle width of tx_now and its return to idle;
- the restart on load;
- a nonzero random word.

The exact tick counts are shown only by the bench's scenarios, which compare every cycle against a behavioural model. These cover the interframe wait chosen by each control-word encoding, including unknown codes, the slot length, and the two-slot guard restarted by interleaved physical and virtual busy.

// File: rtl/backoff_engine.sv
module backoff_engine #(
  parameter int TMR_W = 16,
  parameter int CNT_W = 12,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter logic [TMR_W-1:0] SLOT_RST = 9,
  parameter logic [TMR_W-1:0] SIFS_RST = 10,
  parameter logic [TMR_W-1:0] PIFS_RST = 19,
  parameter logic [TMR_W-1:0] DIFS_RST = 28,
  parameter logic [15:0] CTL_RST = 16'h4c1d,
  localparam int STAT_W = CNT_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              phy_busy,
  input  logic              nav_busy,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic              tx_now,
  output logic [STAT_W-1:0] status,
  output logic [15:0]       rand_val
);
  localparam logic [1:0] S_IDLE = 2'd0, S_IFS = 2'd1, S_CNT = 2'd2, S_FRZ = 2'd3;
  localparam logic [15:0] CW_SIFS = 16'h4021, CW_PIFS = 16'h4d95;
  localparam logic [15:0] CW_DIFS = 16'h4c1d, CW_NOW = 16'h4001;

  logic [TMR_W-1:0] slot_us, sifs_us, pifs_us, difs_us, tmr, ifs_len;
  logic [15:0]      ctl, lfsr;
  logic [1:0]       st;
  logic [CNT_W-1:0] cnt;
  logic             tx_q;

  wire busy = phy_busy | nav_busy;
  wire load = cfg_we && cfg_addr == 3'd5;
  wire [TMR_W:0] tmr_inc = {1'b0, tmr} + 1'b1;
  wire slot_done  = tmr_inc >= {1'b0, slot_us};
  wire guard_done = tmr_inc >= {slot_us, 1'b0};
  wire ifs_done   = tmr >= ifs_len;

  always_comb begin
    case (ctl)
      CW_SIFS: ifs_len = sifs_us;
      CW_PIFS: ifs_len = pifs_us;
      CW_NOW:  ifs_len = '0;
      CW_DIFS: ifs_len = difs_us;
      default: ifs_len = difs_us;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_us <= SLOT_RST;
      sifs_us <= SIFS_RST;
      pifs_us <= PIFS_RST;
      difs_us <= DIFS_RST;
      ctl     <= CTL_RST;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: slot_us <= cfg_wdata[TMR_W-1:0];
        3'd1: sifs_us <= cfg_wdata[TMR_W-1:0];
        3'd2: pifs_us <= cfg_wdata[TMR_W-1:0];
        3'd3: difs_us <= cfg_wdata[TMR_W-1:0];
        3'd4: ctl     <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      tmr  <= '0;
      tx_q <= 1'b0;
    end else begin
      tx_q <= 1'b0;
      if (load) begin
        cnt <= cfg_wdata[CNT_W-1:0];
        st  <= S_IFS;
        tmr <= '0;
      end else begin
        case (st)
          S_IFS:
            if (busy) begin
              st <= S_FRZ; tmr <= '0;
            end else if (ifs_done) begin
              st <= S_CNT; tmr <= '0;
            end else if (us_tick) tmr <= tmr_inc[TMR_W-1:0];
          S_CNT:
            if (busy) begin
              st <= S_FRZ; tmr <= '0;
            end else if (cnt == '0) begin
              st <= S_IDLE; tx_q <= 1'b1;
            end else if (us_tick) begin
              if (slot_done) begin
                cnt <= cnt - 1'b1; tmr <= '0;
              end else tmr <= tmr_inc[TMR_W-1:0];
            end
          S_FRZ:
            if (busy) tmr <= '0;
            else if (us_tick) begin
              if (guard_done) begin
                st <= S_CNT; tmr <= '0;
              end else tmr <= tmr_inc[TMR_W-1:0];
            end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= LFSR_SEED;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  assign tx_now   = tx_q;
  assign status   = {cnt, 2'b00, st};
  assign rand_val = lfsr;

  assert_count_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cnt <= $past(cnt));
  assert_freeze_on_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_IFS || st == S_CNT) && busy && !load) |=> st == S_FRZ);
  assert_hold_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FRZ && busy && !load) |=> (st == S_FRZ && $stable(cnt)));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_now |=> !tx_now);
  assert_pulse_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_now |-> st == S_IDLE);
  assert_rand_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rand_val != 16'h0);
  assert_load_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> st == S_IFS);
endmodule

// File: tb/test_backoff_engine.sv
`timescale 1ns/1ps
module test_backoff_engine;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, us_tick, phy_busy, nav_busy, cfg_we;
  logic [2:0] cfg_addr;
  logic [15:0] cfg_wdata, status, rand_val;
  logic tx_now;

  backoff_engine i_backoff_engine (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .phy_busy(phy_busy),
    .nav_busy(nav_busy), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tx_now(tx_now), .status(status), .rand_val(rand_val));

  int n_cmp = 0, n_bad = 0;
  bit armed = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_st, m_cnt, m_t, m_slot, m_sifs, m_pifs, m_difs, m_ctl;
  bit m_tx;
  logic [15:0] m_rnd;

  function automatic int wait_len();
    if (m_ctl == 'h4021) return m_sifs;
    if (m_ctl == 'h4d95) return m_pifs;
    if (m_ctl == 'h4001) return 0;
    return m_difs;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_t = 0; m_tx = 0;
      m_slot = 9; m_sifs = 10; m_pifs = 19; m_difs = 28; m_ctl = 'h4c1d;
      m_rnd = 16'hACE1;
    end else begin
      bit bsy, nt;
      bsy = phy_busy || nav_busy;
      nt = 0;
      if (cfg_we && cfg_addr == 5) begin
        m_cnt = cfg_wdata % 4096; m_st = 1; m_t = 0;
      end else if (m_st == 1) begin
        if (bsy) begin m_st = 3; m_t = 0; end
        else if (m_t >= wait_len()) begin m_st = 2; m_t = 0; end
        else if (us_tick) m_t = m_t + 1;
      end else if (m_st == 2) begin
        if (bsy) begin m_st = 3; m_t = 0; end
        else if (m_cnt == 0) begin m_st = 0; nt = 1; end
        else if (us_tick) begin
          if (m_t + 1 >= m_slot) begin m_cnt = m_cnt - 1; m_t = 0; end
          else m_t = m_t + 1;
        end
      end else if (m_st == 3) begin
        if (bsy) m_t = 0;
        else if (us_tick) begin
          if (m_t + 1 >= 2 * m_slot) begin m_st = 2; m_t = 0; end
          else m_t = m_t + 1;
        end
      end
      m_tx = nt;
      if (cfg_we) case (cfg_addr)
        0: m_slot = cfg_wdata; 1: m_sifs = cfg_wdata; 2: m_pifs = cfg_wdata;
        3: m_difs = cfg_wdata; 4: m_ctl = cfg_wdata; default: ;
      endcase
      m_rnd = {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
    end
    armed = 1;
  end

  always @(negedge clk) if (armed) begin
    chk(status[1:0] == m_st[1:0], "R8 state field", status[1:0], m_st);
    chk(status[3:2] == 2'b00, "R8 reserved bits", status[3:2], 0);
    chk(status[15:4] == m_cnt[11:0], "R4 remaining count", status[15:4], m_cnt);
    chk(tx_now == m_tx, "R7 tx_now", tx_now, m_tx);
    chk(rand_val == m_rnd, "R9 random word", rand_val, m_rnd);
  end

  initial begin : tick_gen
    int tc = 0;
    us_tick = 0;
    forever begin
      @(negedge clk);
      tc++;
      us_tick = (tc % 4 == 0);
    end
  end

  task automatic wr(input int a, input int d);
    cfg_we = 1; cfg_addr = a[2:0]; cfg_wdata = d[15:0];
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_state(input int s);
    for (int i = 0; i < 2000; i++) begin
      if (status[1:0] == s[1:0]) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_tx(input string tag);
    bit seen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (tx_now) begin seen = 1; break; end
    end
    chk(seen, tag, seen, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    int held;
    rst_n = 0; phy_busy = 0; nav_busy = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    chk(status == 16'h0, "R1 reset status", status, 0);
    chk(tx_now == 0, "R1 reset tx_now", tx_now, 0);
    chk(rand_val == 16'hACE1, "R1 reset seed", rand_val, 16'hACE1);
    rst_n = 1;
    @(negedge clk);

    // R2 default lengths: DIFS 28 us, count 1
    wr(5, 1);
    chk(status[1:0] == 2'b01, "R2 load enters wait", status[1:0], 1);
    wait_tx("R2 default DIFS run ends");

    wr(0, 3); wr(1, 2); wr(2, 4); wr(3, 5);

    // R3 zero wait, count 0: pulse two clocks after load
    wr(4, 'h4001); wr(5, 0);
    @(negedge clk);
    chk(status[1:0] == 2'b10, "R3 zero wait to counting", status[1:0], 2);
    @(negedge clk);
    chk(tx_now == 1, "R3 R7 immediate pulse", tx_now, 1);
    chk(status == 16'h0, "R7 back to idle", status, 0);
    @(negedge clk);
    chk(tx_now == 0, "R7 pulse one cycle", tx_now, 0);

    // R3 SIFS, R4 countdown
    wr(4, 'h4021); wr(5, 3);
    wait_tx("R4 SIFS countdown ends");

    // R5 / R6 freeze and guard
    wr(4, 'h4c1d); wr(5, 6);
    wait_state(2);
    repeat (14) @(negedge clk);
    held = status[15:4];
    phy_busy = 1;
    @(negedge clk);
    chk(status[1:0] == 2'b11, "R5 phy busy freezes", status[1:0], 3);
    repeat (20) @(negedge clk);
    chk(status[15:4] == held, "R5 count held", status[15:4], held);
    phy_busy = 0;
    repeat (10) @(negedge clk);
    nav_busy = 1;
    @(negedge clk);
    chk(status[1:0] == 2'b11, "R5 nav busy keeps frozen", status[1:0], 3);
    repeat (4) @(negedge clk);
    nav_busy = 0;
    repeat (20) @(negedge clk);
    chk(status[1:0] == 2'b11, "R6 guard not yet elapsed", status[1:0], 3);
    wait_state(2);
    chk(status[1:0] == 2'b10, "R6 resumes counting", status[1:0], 2);
    wait_tx("R6 frozen run ends");

    // R10 reload while counting
    wr(5, 9);
    wait_state(2);
    repeat (30) @(negedge clk);
    wr(5, 2);
    chk(status == 16'h0021, "R10 reload restarts wait", status, 16'h0021);
    wait_tx("R10 reloaded run ends");

    // R3 unknown code falls back to DIFS
    wr(4, 'h1234); wr(5, 1);
    wait_tx("R3 unknown code run ends");

    // R3 PIFS with random busy noise
    wr(4, 'h4d95); wr(5, 4);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      phy_busy = ($urandom % 16) == 0;
      nav_busy = ($urandom % 23) == 0;
    end
    phy_busy = 0; nav_busy = 0;
    wait_tx("R3 PIFS noisy run ends");

    // R2 slot length change
    wr(0, 1); wr(5, 4);
    wait_tx("R2 new slot length run ends");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule